// File: doc/BRIEF.md
# Linked-Buffer Receive DMA Engine

This block takes packets arriving as a stream of 32-bit words and copies them into host memory by itself. The host builds a chain of buffer descriptors in memory, loads the address of the first one, and sets the enable bit. From then on the engine works without the processor. It fetches each descriptor and fills its buffer with incoming words. It writes a completion status back into the descriptor and then follows the link to the next one. A packet longer than one buffer simply continues into the following buffers.

Each finished buffer raises a level interrupt, which stays high until the host writes the acknowledge register. When a packet arrives and no usable descriptor is left, the packet is still consumed from the stream but is thrown away, and an overrun flag is raised.

Memory is reached through a single-beat request port with word addresses. A request is held until the memory returns an acknowledge. A descriptor at word address P occupies P..P+3.

Top module: `rx_chain_dma`

## Requirements
- R1: While reset is high, and on the first cycle after it, `irq`, `overrun`, `mem_req` and `in_ready` are all 0. The engine also comes out of reset disabled, with a null chain pointer.
- R2: While the enable bit is 0 and no descriptor is loaded, `in_ready` stays 0 and no memory request is issued, whatever the stream input does. The enable bit is written with `reg_sel`=1, data bit 0.
- R3: A write with `reg_sel`=0 loads the chain pointer while the engine is idle. Once enabled with a nonzero pointer P, the engine reads P+0 (buffer address) and then P+1 (length in bits LW-1:0, owner flag in bit 31). If the owner flag is 1 it then reads P+2 (next pointer). These are single-beat reads in that order.
- R4: The packet words that fill one buffer are written to consecutive addresses starting at that buffer's address, in arrival order.
- R5: When a buffer fills before the packet's last word, the rest of the packet goes into the next descriptor's buffer, with no host action.
- R6: Each buffer ends with a write of the status word to P+3, after its last data write and before any read of the next descriptor. In the status word, bit 31 (done) is 1. Bit 30 (end of packet) is 1 only when the buffer holds the packet's last word. Bits LW-1:0 hold the number of words written.
- R7: The chain has no usable descriptor when the pointer is 0 or the fetched owner flag is 0. A packet that starts in this state is accepted on the stream and discarded, and `overrun` is set. A packet that runs out of descriptors part way has the rest of its words discarded, and `overrun` is set.
- R8: `irq` rises on the cycle after each status write is acknowledged. It stays high through later completions until a write with `reg_sel`=2, which clears both `irq` and `overrun`. A completion in the same cycle as that write wins.
- R9: A memory request keeps its address, direction and write data stable until acknowledged. The stream is never accepted while a memory request is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Host register write strobe |
| reg_sel | input | 2 | Register select: 0 chain pointer, 1 enable, 2 acknowledge |
| reg_wdata | input | W | Host write data |
| irq | output | 1 | Level interrupt, one or more buffers completed |
| overrun | output | 1 | Sticky flag, packet data was dropped |
| in_valid | input | 1 | Stream word valid |
| in_data | input | W | Stream word |
| in_last | input | 1 | Marks the last word of a packet |
| in_ready | output | 1 | Engine accepts the stream word |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | W | Word address |
| mem_wdata | output | W | Write data |
| mem_rdata | input | W | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Memory completes the request |

## Verification
The engine is tried with the following cases:

- A short packet that partly fills one buffer, which shows the count and end-of-packet marking.
- A packet spanning two buffers, which separates buffer chaining from packet boundaries.
- A packet that fills a buffer exactly at the chain's end, which checks that end-of-packet and buffer-full coincide correctly.
- A packet with no descriptor at all.
- A packet that meets a descriptor the host does not own, part way through.

The last two separate the two drop paths. Every memory access is compared in order against a model queue, which also catches a status write placed after the next descriptor fetch. The interrupt is compared every clock against a behavioural model.

// File: rtl/rx_chain_dma_pkg.sv
package rx_chain_dma_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_BUF,
    ST_RD_LEN,
    ST_RD_NXT,
    ST_TAKE,
    ST_PUT,
    ST_STAT,
    ST_DROP
  } walk_state_e;

  // word offsets inside one descriptor
  localparam int unsigned OFS_BUF  = 0;
  localparam int unsigned OFS_LEN  = 1;
  localparam int unsigned OFS_NXT  = 2;
  localparam int unsigned OFS_STAT = 3;

  // host register select codes
  localparam logic [1:0] SEL_HEAD = 2'd0;
  localparam logic [1:0] SEL_EN   = 2'd1;
  localparam logic [1:0] SEL_ACK  = 2'd2;

endpackage

// File: rtl/rx_chain_hostregs.sv
module rx_chain_hostregs
  import rx_chain_dma_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         reg_wr,
  input  logic [1:0]   reg_sel,
  input  logic [W-1:0] reg_wdata,
  input  logic         done_evt,
  input  logic         ovr_evt,
  output logic         enable,
  output logic         head_we,
  output logic [W-1:0] head_val,
  output logic         irq,
  output logic         overrun
);

  logic ack_wr;

  assign ack_wr   = reg_wr && (reg_sel == SEL_ACK);
  assign head_we  = reg_wr && (reg_sel == SEL_HEAD);
  assign head_val = reg_wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      enable  <= 1'b0;
      irq     <= 1'b0;
      overrun <= 1'b0;
    end else begin
      if (reg_wr && (reg_sel == SEL_EN)) enable <= reg_wdata[0];
      if (done_evt)    irq <= 1'b1;
      else if (ack_wr) irq <= 1'b0;
      if (ovr_evt)     overrun <= 1'b1;
      else if (ack_wr) overrun <= 1'b0;
    end
  end

endmodule

// File: rtl/rx_chain_walker.sv
module rx_chain_walker
  import rx_chain_dma_pkg::*;
#(
  parameter int unsigned W  = 32,
  parameter int unsigned LW = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         enable,
  input  logic         head_we,
  input  logic [W-1:0] head_val,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  input  logic         in_last,
  output logic         in_ready,
  output logic         mem_req,
  output logic         mem_we,
  output logic [W-1:0] mem_addr,
  output logic [W-1:0] mem_wdata,
  input  logic [W-1:0] mem_rdata,
  input  logic         mem_ack,
  output logic         done_evt,
  output logic         ovr_evt
);

  localparam int unsigned OWN_BIT  = W - 1;
  localparam int unsigned DONE_BIT = W - 1;
  localparam int unsigned EOP_BIT  = W - 2;

  walk_state_e  state;
  logic [W-1:0] ptr;
  logic [W-1:0] buf_base;
  logic [W-1:0] nxt;
  logic [LW-1:0] buf_len;
  logic [LW-1:0] cnt;
  logic          last_q;
  logic          eop_q;
  logic [LW-1:0] cnt_inc;

  assign cnt_inc  = cnt + 1'b1;
  assign in_ready = (state == ST_TAKE) || (state == ST_DROP);
  assign done_evt = (state == ST_STAT) && mem_ack;
  assign ovr_evt  = ((state == ST_IDLE) && !head_we && enable &&
                     (ptr == '0) && in_valid) ||
                    ((state == ST_STAT) && mem_ack && !eop_q && (nxt == '0));

  function automatic logic [W-1:0] stat_word(input logic eop, input logic [LW-1:0] n);
    logic [W-1:0] s;
    s           = '0;
    s[LW-1:0]   = n;
    s[DONE_BIT] = 1'b1;
    s[EOP_BIT]  = eop;
    return s;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      ptr       <= '0;
      buf_base  <= '0;
      nxt       <= '0;
      buf_len   <= '0;
      cnt       <= '0;
      last_q    <= 1'b0;
      eop_q     <= 1'b0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (head_we) begin
            ptr <= head_val;
          end else if (enable && (ptr != '0)) begin
            mem_req  <= 1'b1;
            mem_we   <= 1'b0;
            mem_addr <= ptr + W'(OFS_BUF);
            state    <= ST_RD_BUF;
          end else if (enable && in_valid) begin
            state <= ST_DROP;
          end
        end
        ST_RD_BUF: if (mem_ack) begin
          buf_base <= mem_rdata;
          mem_addr <= ptr + W'(OFS_LEN);
          state    <= ST_RD_LEN;
        end
        ST_RD_LEN: if (mem_ack) begin
          if (!mem_rdata[OWN_BIT]) begin
            ptr     <= '0;
            mem_req <= 1'b0;
            state   <= ST_IDLE;
          end else begin
            buf_len  <= mem_rdata[LW-1:0];
            mem_addr <= ptr + W'(OFS_NXT);
            state    <= ST_RD_NXT;
          end
        end
        ST_RD_NXT: if (mem_ack) begin
          nxt     <= mem_rdata;
          mem_req <= 1'b0;
          cnt     <= '0;
          state   <= ST_TAKE;
        end
        ST_TAKE: if (in_valid) begin
          last_q    <= in_last;
          mem_req   <= 1'b1;
          mem_we    <= 1'b1;
          mem_addr  <= buf_base + W'(cnt);
          mem_wdata <= in_data;
          state     <= ST_PUT;
        end
        ST_PUT: if (mem_ack) begin
          cnt <= cnt_inc;
          if (last_q || (cnt_inc == buf_len)) begin
            eop_q     <= last_q;
            mem_addr  <= ptr + W'(OFS_STAT);
            mem_wdata <= stat_word(last_q, cnt_inc);
            state     <= ST_STAT;
          end else begin
            mem_req <= 1'b0;
            state   <= ST_TAKE;
          end
        end
        ST_STAT: if (mem_ack) begin
          ptr <= nxt;
          if (eop_q) begin
            mem_req <= 1'b0;
            state   <= ST_IDLE;
          end else if (nxt == '0) begin
            mem_req <= 1'b0;
            state   <= ST_DROP;
          end else begin
            mem_we   <= 1'b0;
            mem_addr <= nxt + W'(OFS_BUF);
            state    <= ST_RD_BUF;
          end
        end
        ST_DROP: if (in_valid && in_last) begin
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/rx_chain_dma.sv
module rx_chain_dma #(
  parameter int unsigned W  = 32,
  parameter int unsigned LW = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         reg_wr,
  input  logic [1:0]   reg_sel,
  input  logic [W-1:0] reg_wdata,
  output logic         irq,
  output logic         overrun,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  input  logic         in_last,
  output logic         in_ready,
  output logic         mem_req,
  output logic         mem_we,
  output logic [W-1:0] mem_addr,
  output logic [W-1:0] mem_wdata,
  input  logic [W-1:0] mem_rdata,
  input  logic         mem_ack
);

  logic         enable;
  logic         head_we;
  logic [W-1:0] head_val;
  logic         done_evt;
  logic         ovr_evt;

  rx_chain_hostregs #(.W(W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .done_evt  (done_evt),
    .ovr_evt   (ovr_evt),
    .enable    (enable),
    .head_we   (head_we),
    .head_val  (head_val),
    .irq       (irq),
    .overrun   (overrun)
  );

  rx_chain_walker #(.W(W), .LW(LW)) u_walk (
    .clk       (clk),
    .rst       (rst),
    .enable    (enable),
    .head_we   (head_we),
    .head_val  (head_val),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_last   (in_last),
    .in_ready  (in_ready),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .mem_ack   (mem_ack),
    .done_evt  (done_evt),
    .ovr_evt   (ovr_evt)
  );

endmodule

// File: rtl/rx_chain_dma_chk.sv
module rx_chain_dma_chk #(
  parameter int unsigned W  = 32,
  parameter int unsigned LW = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         reg_wr,
  input logic [1:0]   reg_sel,
  input logic [W-1:0] reg_wdata,
  input logic         irq,
  input logic         overrun,
  input logic         in_valid,
  input logic [W-1:0] in_data,
  input logic         in_last,
  input logic         in_ready,
  input logic         mem_req,
  input logic         mem_we,
  input logic [W-1:0] mem_addr,
  input logic [W-1:0] mem_wdata,
  input logic [W-1:0] mem_rdata,
  input logic         mem_ack
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!irq && !overrun && !mem_req && !in_ready));

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) &&
                               $stable(mem_we) && $stable(mem_wdata)));

  // R9
  ready_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(in_ready && mem_req));

  // R8
  irq_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (irq && !(reg_wr && reg_sel == 2'd2)) |=> irq);

  // R8
  irq_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(mem_req && mem_we && mem_ack && mem_wdata[W-1]));

  // R7
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (overrun && !(reg_wr && reg_sel == 2'd2)) |=> overrun);

endmodule

bind rx_chain_dma rx_chain_dma_chk #(.W(W), .LW(LW)) u_chk (.*);

// File: tb/rx_chain_dma_tb.sv
module rx_chain_dma_tb;
  localparam int W = 32;
  localparam int LW = 16;
  localparam time CLK_PERIOD = 10ns;

  logic         clk = 1'b0;
  logic         rst;
  logic         reg_wr;
  logic [1:0]   reg_sel;
  logic [W-1:0] reg_wdata;
  logic         irq, overrun;
  logic         in_valid, in_last, in_ready;
  logic [W-1:0] in_data;
  logic         mem_req, mem_we, mem_ack;
  logic [W-1:0] mem_addr, mem_wdata, mem_rdata;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  logic [W-1:0] mem [0:1023];
  logic         q_we[$];
  logic [W-1:0] q_addr[$];
  logic [W-1:0] q_data[$];
  logic [W-1:0] m_ptr;
  bit           m_have;
  bit           exp_ovr;
  logic         mdl_irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_chain_dma #(.W(W), .LW(LW)) u_dut (.*);

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
    end
  endtask

  // memory responder: acknowledges one cycle after a request appears
  always @(posedge clk) begin
    if (rst) mem_ack <= 1'b0;
    else if (mem_req && !mem_ack) begin
      mem_ack   <= 1'b1;
      mem_rdata <= mem[mem_addr[9:0]];
      if (mem_we) mem[mem_addr[9:0]] <= mem_wdata;
    end else mem_ack <= 1'b0;
  end

  // interrupt reference model
  always @(posedge clk) begin
    if (rst) mdl_irq <= 1'b0;
    else if (mem_req && mem_we && mem_ack && mem_wdata[W-1]) mdl_irq <= 1'b1;
    else if (reg_wr && reg_sel == 2'd2) mdl_irq <= 1'b0;
  end

  // per-clock comparison
  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk(irq === mdl_irq, "R8 irq level", W'(irq), W'(mdl_irq));
      if (mem_req && mem_ack) begin
        if (q_we.size() == 0) begin
          chk(1'b0, "R6 unexpected access", mem_addr, '0);
        end else begin
          logic we_e; logic [W-1:0] a_e, d_e;
          we_e = q_we.pop_front(); a_e = q_addr.pop_front(); d_e = q_data.pop_front();
          chk(mem_we === we_e && mem_addr === a_e, "R3/R4 access order",
              mem_addr, a_e);
          if (we_e && mem_we)
            chk(mem_wdata === d_e, "R4/R6 write data", mem_wdata, d_e);
        end
      end
    end
  end

  task automatic push(input logic we, input logic [W-1:0] a, input logic [W-1:0] d);
    q_we.push_back(we); q_addr.push_back(a); q_data.push_back(d);
  endtask

  task automatic set_desc(input int p, input logic [W-1:0] b, input int len,
                          input logic [W-1:0] nx, input bit own);
    mem[p]   = b;
    mem[p+1] = {own, 15'd0, 16'(len)};
    mem[p+2] = nx;
    mem[p+3] = '0;
  endtask

  task automatic m_fetch(input logic [W-1:0] p);
    push(1'b0, p, '0);
    push(1'b0, p + 1, '0);
    if (mem[p[9:0] + 10'd1][W-1]) begin
      push(1'b0, p + 2, '0);
      m_have = 1; m_ptr = p;
    end else begin
      m_have = 0; m_ptr = '0;
    end
  endtask

  task automatic m_packet(input int n, input logic [W-1:0] base);
    int i = 0;
    while (i < n) begin
      int cnt = 0;
      int len;
      logic [W-1:0] b, nx;
      bit eop;
      if (!m_have) begin exp_ovr = 1; break; end
      b   = mem[m_ptr[9:0]];
      len = int'(mem[m_ptr[9:0] + 10'd1][15:0]);
      nx  = mem[m_ptr[9:0] + 10'd2];
      while (i < n && cnt < len) begin
        push(1'b1, b + W'(cnt), base + W'(i));
        i++; cnt++;
      end
      eop = (i == n);
      push(1'b1, m_ptr + 3, {1'b1, eop, 14'd0, 16'(cnt)});
      m_have = 0; m_ptr = nx;
      if (nx != 0) m_fetch(nx);
      if (!eop && !m_have) begin exp_ovr = 1; break; end
    end
  endtask

  task automatic reg_write(input logic [1:0] s, input logic [W-1:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic send_pkt(input int n, input logic [W-1:0] base);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_data = base + W'(i); in_last = (i == n - 1);
      while (!in_ready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic settle(input string req);
    repeat (30) @(negedge clk);
    chk(q_we.size() == 0, req, W'(q_we.size()), '0);
    chk(overrun === exp_ovr, "R7 overrun flag", W'(overrun), W'(exp_ovr));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_bad++;
      $display("FAIL watchdog expired: actual running expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 1024; k++) mem[k] = '0;
    rst = 1; reg_wr = 0; reg_sel = 0; reg_wdata = '0;
    in_valid = 0; in_last = 0; in_data = '0;
    m_ptr = '0; m_have = 0; exp_ovr = 0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk(!irq && !overrun && !mem_req && !in_ready, "R1 reset outputs",
        {28'd0, irq, overrun, mem_req, in_ready}, '0);
    rst = 0;
    @(negedge clk);
    chk(!irq && !overrun && !mem_req && !in_ready, "R1 after reset",
        {28'd0, irq, overrun, mem_req, in_ready}, '0);

    // R2: disabled engine ignores the stream
    in_valid = 1; in_data = 32'h55; in_last = 1;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      chk(!in_ready && !mem_req, "R2 disabled idle", {30'd0, in_ready, mem_req}, '0);
    end
    in_valid = 0; in_last = 0;

    // chain of four descriptors
    set_desc(32'h10, 32'h100, 4, 32'h14, 1);
    set_desc(32'h14, 32'h120, 3, 32'h18, 1);
    set_desc(32'h18, 32'h140, 8, 32'h1C, 1);
    set_desc(32'h1C, 32'h160, 2, 32'h00, 1);

    // R10-style load then enable: R3 fetch order
    reg_write(2'd0, 32'h10);
    repeat (3) @(negedge clk);
    chk(!mem_req, "R2 pointer set but disabled", W'(mem_req), '0);
    m_fetch(32'h10);
    reg_write(2'd1, 32'h1);
    settle("R3 first fetch");

    // R4/R6: short packet, partial buffer
    m_packet(2, 32'h1000);
    send_pkt(2, 32'h1000);
    settle("R4 short packet");
    chk(mem[10'h13] === 32'hC000_0002, "R6 status eop short", mem[10'h13], 32'hC000_0002);
    reg_write(2'd2, 32'h0);

    // R5: packet spans two buffers, no ack between completions (R8)
    m_packet(7, 32'h2000);
    send_pkt(7, 32'h2000);
    settle("R5 spanning packet");
    chk(mem[10'h17] === 32'h8000_0003, "R6 status no eop", mem[10'h17], 32'h8000_0003);
    chk(mem[10'h1B] === 32'hC000_0004, "R5 continued buffer status", mem[10'h1B], 32'hC000_0004);
    chk(mem[10'h143] === 32'h2006, "R5 last word placed", mem[10'h143], 32'h2006);
    chk(irq === 1'b1, "R8 irq held", W'(irq), 1);

    // exact fill at the end of chain
    m_packet(2, 32'h3000);
    send_pkt(2, 32'h3000);
    settle("R6 exact fill");
    chk(mem[10'h1F] === 32'hC000_0002, "R6 exact fill eop", mem[10'h1F], 32'hC000_0002);

    // R7: no descriptor left
    m_packet(3, 32'h4000);
    send_pkt(3, 32'h4000);
    settle("R7 dropped packet");
    chk(overrun === 1'b1, "R7 overrun set", W'(overrun), 1);

    // R8: acknowledge clears both
    reg_write(2'd2, 32'h0);
    exp_ovr = 0;
    @(negedge clk);
    chk(!irq && !overrun, "R8 ack clears", {30'd0, irq, overrun}, '0);

    // R7: descriptor not owned, hit mid-packet
    set_desc(32'h30, 32'h200, 2, 32'h34, 1);
    set_desc(32'h34, 32'h220, 4, 32'h00, 0);
    reg_write(2'd0, 32'h30);
    m_fetch(32'h30);
    settle("R3 second chain fetch");
    m_packet(5, 32'h5000);
    send_pkt(5, 32'h5000);
    settle("R7 mid-packet drop");
    chk(mem[10'h33] === 32'h8000_0002, "R7 partial status", mem[10'h33], 32'h8000_0002);
    chk(mem[10'h220] === 32'h0, "R7 unowned buffer untouched", mem[10'h220], 32'h0);
    chk(in_ready === 1'b0, "R9 idle after drop", W'(in_ready), 0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule